// File: doc/BRIEF.md
# Supply Warning and Retention Controller

This block watches three supply comparator outputs and turns them into processor-facing controls. The three inputs indicate that the supply has fallen below the warning level, below the lowest level at which the processor may run, and below the backup cell voltage. Each input is asynchronous to the core clock, so each one is re-timed into the clock domain before any logic uses it.

A falling supply sets a sticky warning flag. The flag can raise a maskable interrupt, which gives software time to save its state before the supply fails. Software sees the flag and its enable bit in an 8-bit control register. Reading that register clears the flag. If the supply is still below the warning level at the time of the read, the flag stays set.

Two digital outputs are driven from the comparator inputs. The first places memory in its data-retention state when the supply drops below the operating minimum. The second selects the backup cell as the supply source. The analog comparators and the power switch lie outside this block.

Top module: `pfw_monitor`

## Requirements
- R1: While `rst` is high, and after it falls, the flag, enable, `warn_irq`, `retain_en`, `batt_sel` and `reg_rdata` are all 0.
- R2: A change on `cmp_warn_raw` reaches the flag at the third rising clock edge after the change. Two of these edges are synchronizer stages and one is the flag register. The flag is set on every edge at which the synchronized warning is high.
- R3: Once set, the flag stays 1 after the supply recovers, until a register read clears it.
- R4: A read (`reg_rd` high for one edge) loads `reg_rdata` at that edge. Bit 5 holds the flag, bit 3 holds the enable, and every other bit is 0. If the synchronized warning is low at that edge, the same edge clears the flag.
- R5: If the synchronized warning is still high at the edge of a read, the flag stays 1, because setting the flag takes priority over clearing it.
- R6: A write (`reg_wr` high) loads the enable from `reg_wdata` bit 3. The written value of bit 5 and of all other bits has no effect on the flag or on the read-back value.
- R7: `warn_irq` is a register that goes to 1 at the same edge at which both the flag and the enable become 1. It goes to 0 at the edge at which either of them becomes 0.
- R8: `retain_en` follows `cmp_min_raw` with a delay of three rising edges.
- R9: `batt_sel` is 1 only when both the synchronized minimum input and the synchronized backup input are high. It has the same three-edge delay, and it is never 1 while `retain_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cmp_warn_raw | input | 1 | Asynchronous comparator: supply is below the warning level |
| cmp_min_raw | input | 1 | Asynchronous comparator: supply is below the operating minimum |
| cmp_batt_raw | input | 1 | Asynchronous comparator: supply is below the backup cell voltage |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Control register read strobe; clears the flag |
| reg_wdata | input | 8 | Write data; only bit 3 is stored |
| reg_rdata | output | 8 | Read data, loaded on a read |
| warn_irq | output | 1 | Warning interrupt request |
| retain_en | output | 1 | Data-retention state control |
| batt_sel | output | 1 | Selects the backup cell as the supply source |

## Verification
The assertions assume that a read strobe lasts one clock edge. They also assume that the comparator inputs change slowly compared with the clock, so each level holds for several cycles after synchronization. Stimulus only changes the comparator inputs and the strobes just after a falling edge. It then waits at least three rising edges before it samples any result that depends on a comparator input, so no check lands inside the synchronizer window. The bench exercises every read-clear case against a comparator level that has already settled: warning still active and warning already recovered.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  localparam int REG_W    = 8;
  localparam int FLAG_BIT = 5;
  localparam int EN_BIT   = 3;
  localparam logic [REG_W-1:0] EN_MASK = REG_W'(1) << EN_BIT;
  localparam int CMP_W    = 3;

  typedef struct packed {
    logic warn;
    logic vmin;
    logic batt;
  } supply_t;
endpackage

// File: rtl/pfw_sync.sv
module pfw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  for (genvar s = 0; s < STAGES; s++) begin : g_st
    logic [W-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= g_st[s-1].q;
      end
    end
  end

  assign d_out = g_st[STAGES-1].q;
endmodule

// File: rtl/pfw_ctrl_reg.sv
module pfw_ctrl_reg
  import pfw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             warn_s,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             irq
);
  logic             flag_q, en_q, irq_q;
  logic             flag_d, en_d;
  logic [REG_W-1:0] image, rdata_q;

  // set has priority over the read-clear
  always_comb begin
    flag_d = warn_s | (flag_q & ~rd_en);
    en_d   = wr_en ? |(wdata & EN_MASK) : en_q;
    image  = '0;
    image[FLAG_BIT] = flag_q;
    image[EN_BIT]   = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      flag_q  <= flag_d;
      en_q    <= en_d;
      irq_q   <= flag_d & en_d;
      if (rd_en) rdata_q <= image;
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (rst)
    warn_s |=> flag_q);
  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !rd_en) |=> flag_q);
  assert_read_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !warn_s) |=> !flag_q);
  assert_read_image_R4: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rdata[FLAG_BIT] == $past(flag_q) && rdata[EN_BIT] == $past(en_q)));
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && warn_s) |=> flag_q);
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    irq == (flag_q & en_q));
endmodule

// File: rtl/pfw_supply_ctl.sv
module pfw_supply_ctl (
  input  logic clk,
  input  logic rst,
  input  logic vmin_s,
  input  logic batt_s,
  output logic retain,
  output logic batt_sel
);
  logic retain_q, batt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      retain_q <= 1'b0;
      batt_q   <= 1'b0;
    end else begin
      retain_q <= vmin_s;
      batt_q   <= vmin_s & batt_s;
    end
  end

  assign retain   = retain_q;
  assign batt_sel = batt_q;

  assert_retain_on_R8: assert property (@(posedge clk) disable iff (rst)
    vmin_s |=> retain);
  assert_retain_off_R8: assert property (@(posedge clk) disable iff (rst)
    !vmin_s |=> !retain);
  assert_batt_needs_retain_R9: assert property (@(posedge clk) disable iff (rst)
    batt_sel |-> retain);
endmodule

// File: rtl/pfw_monitor.sv
module pfw_monitor
  import pfw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_warn_raw,
  input  logic             cmp_min_raw,
  input  logic             cmp_batt_raw,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             warn_irq,
  output logic             retain_en,
  output logic             batt_sel
);
  supply_t raw, synced;

  assign raw = '{warn: cmp_warn_raw, vmin: cmp_min_raw, batt: cmp_batt_raw};

  pfw_sync #(.W(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (raw),
    .d_out (synced)
  );

  pfw_ctrl_reg u_reg (
    .clk    (clk),
    .rst    (rst),
    .warn_s (synced.warn),
    .wr_en  (reg_wr),
    .rd_en  (reg_rd),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .irq    (warn_irq)
  );

  pfw_supply_ctl u_supply (
    .clk      (clk),
    .rst      (rst),
    .vmin_s   (synced.vmin),
    .batt_s   (synced.batt),
    .retain   (retain_en),
    .batt_sel (batt_sel)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!warn_irq && !retain_en && !batt_sel && reg_rdata == '0));
endmodule

// File: tb/test_pfw_monitor.sv
module test_pfw_monitor;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmp_warn_raw = 1'b0, cmp_min_raw = 1'b0, cmp_batt_raw = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       warn_irq, retain_en, batt_sel;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pfw_monitor i_pfw_monitor (
    .clk(clk), .rst(rst),
    .cmp_warn_raw(cmp_warn_raw), .cmp_min_raw(cmp_min_raw), .cmp_batt_raw(cmp_batt_raw),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .warn_irq(warn_irq), .retain_en(retain_en), .batt_sel(batt_sel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(output logic [7:0] d);
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic do_write(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rst = 1'b1;
    wait_n(3);
    chk("R1 irq in reset", {7'd0, warn_irq}, 8'h00);
    rst = 1'b0;
    wait_n(1);
    chk("R1 outputs after reset", {5'd0, warn_irq, retain_en, batt_sel}, 8'h00);
    chk("R1 rdata after reset", reg_rdata, 8'h00);
    do_read(d);
    chk("R1 register after reset", d, 8'h00);
  endtask

  task automatic t_warn_set;
    logic [7:0] d;
    do_write(8'h08);
    cmp_warn_raw = 1'b1;
    wait_n(2);
    chk("R2 not yet set after two edges", {7'd0, warn_irq}, 8'h00);
    wait_n(1);
    chk("R2 R7 flag and irq at third edge", {7'd0, warn_irq}, 8'h01);
    cmp_warn_raw = 1'b0;
    wait_n(5);
    chk("R3 flag sticky after recovery", {7'd0, warn_irq}, 8'h01);
    do_read(d);
    chk("R4 read image", d, 8'h28);
    chk("R7 irq drops with clear", {7'd0, warn_irq}, 8'h00);
    do_read(d);
    chk("R4 flag cleared by read", d, 8'h08);
  endtask

  task automatic t_clear_low;
    logic [7:0] d;
    cmp_warn_raw = 1'b1;
    wait_n(4);
    do_read(d);
    chk("R5 first read while low", d, 8'h28);
    chk("R5 irq held while low", {7'd0, warn_irq}, 8'h01);
    do_read(d);
    chk("R5 flag re-set while low", d, 8'h28);
    cmp_warn_raw = 1'b0;
    wait_n(4);
    do_read(d);
    chk("R3 flag kept after recovery", d, 8'h28);
    do_read(d);
    chk("R4 cleared once recovered", d, 8'h08);
  endtask

  task automatic t_irq_mask;
    logic [7:0] d;
    do_write(8'h20);
    cmp_warn_raw = 1'b1;
    wait_n(4);
    chk("R7 irq masked", {7'd0, warn_irq}, 8'h00);
    do_read(d);
    chk("R6 written bit5 ignored, enable off", d, 8'h20);
    do_write(8'h08);
    chk("R7 irq on enable write", {7'd0, warn_irq}, 8'h01);
    do_write(8'h00);
    chk("R7 irq off on disable", {7'd0, warn_irq}, 8'h00);
    cmp_warn_raw = 1'b0;
    wait_n(4);
    do_read(d);
    do_read(d);
    chk("R4 flag cleared", d, 8'h00);
    do_write(8'hFF);
    do_read(d);
    chk("R6 only enable stored", d, 8'h08);
    chk("R6 no irq from write", {7'd0, warn_irq}, 8'h00);
  endtask

  task automatic t_supply;
    cmp_min_raw = 1'b1;
    wait_n(2);
    chk("R8 retain delayed", {7'd0, retain_en}, 8'h00);
    wait_n(1);
    chk("R8 retain at third edge", {7'd0, retain_en}, 8'h01);
    chk("R9 no battery without low cell", {7'd0, batt_sel}, 8'h00);
    cmp_batt_raw = 1'b1;
    wait_n(2);
    chk("R9 battery delayed", {7'd0, batt_sel}, 8'h00);
    wait_n(1);
    chk("R9 battery selected", {7'd0, batt_sel}, 8'h01);
    cmp_min_raw = 1'b0;
    wait_n(3);
    chk("R8 retain released", {7'd0, retain_en}, 8'h00);
    chk("R9 battery needs both", {7'd0, batt_sel}, 8'h00);
    cmp_batt_raw = 1'b0;
    wait_n(3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_warn_set();
    t_clear_low();
    t_irq_mask();
    t_supply();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule